// File: doc/BRIEF.md
# Branch Promotion and Frame Builder

This block watches the stream of retired instructions and cuts it into frames: runs of consecutive basic blocks that later stages can fetch and transform as one unit. Each conditional or indirect branch is looked up in a small direct-mapped bias table. The table counts how many times in a row that branch has repeated its last direction or its last target. A branch whose run is long enough is treated as an assertion. The frame keeps it and counts it, and it does not end the frame. Any control instruction that is not promoted ends the frame. The instruction that follows it is a branch target and opens the next frame.

A frame that has closed is reported as a descriptor: start PC, instruction count and assertion count, with a one-cycle valid strobe. A frame is reported only if it is longer than a minimum size. A frame that reaches a maximum length is closed by force. When an assertion fires later in the pipeline, the caller sends a demotion request for that branch. The request clears the branch's run count, so the branch has to requalify before it is promoted again.

The frame controller has three states:
- SEEK: the state after reset. The block waits for the first unpromoted control instruction and ignores everything before it.
- ARMED: the next retired instruction starts a frame.
- BUILD: a frame is open and instructions are being accumulated.

Its transitions are:
- SEEK→ARMED on an unpromoted control instruction.
- ARMED→BUILD on an instruction that does not close the frame.
- ARMED→ARMED and BUILD→ARMED on a close, whether an unpromoted control instruction or the length cap.
- BUILD→BUILD on any other instruction.
- Every state holds on a cycle with no retired instruction.

Top module: `frame_builder`

## Requirements
- R1: After reset, no frame is open (state SEEK). frm_valid, frm_start_pc, frm_len and frm_asserts are zero. Every bias entry has count zero, recorded direction not-taken (0) and recorded target zero.
- R2: Each retired conditional branch (ret_kind = 1) updates the conditional entry at its index. If ret_taken equals the recorded direction, the count increments, saturating at 2^CNT_W-1. Otherwise the count becomes zero and ret_taken is recorded.
- R3: Each retired indirect branch (ret_kind = 2) updates the indirect entry at its index in the same way, comparing ret_target with the recorded target. The two tables are separate.
- R4: A conditional or indirect branch is promoted when, before its own update, its entry's count is at least PROMOTE_TH and its outcome matches the recorded one. A promoted branch stays in the frame and adds one to the frame's assertion count. Kind 3 is never promoted.
- R5: A demotion request (dem_valid, with dem_indirect = 0 for the conditional table and 1 for the indirect table) clears the count of the entry that dem_pc indexes. When the request and a retired branch hit the same entry in the same cycle, the count is still cleared.
- R6: Kind encoding is 0 = non-control, 1 = conditional, 2 = indirect, 3 = other control. An unpromoted control instruction (kind 1 to 3) closes the frame and is counted as its last instruction. The next retired instruction opens a new frame at its PC. After reset, instructions are ignored until the first unpromoted control instruction.
- R7: A closed frame is reported only if its instruction count is greater than MIN_LEN. Shorter frames are dropped without a strobe.
- R8: A frame whose count reaches MAX_LEN closes on that instruction, even if the instruction is a promoted branch. The next instruction opens a new frame.
- R9: frm_valid is a one-cycle pulse in the cycle after the closing instruction is retired. The start PC, length and assertion count hold their values until the next reported frame.
- R10: The table index is the XOR fold of the PC: bit b of the PC flips index bit (b mod IDX_W). PCs with equal folds share an entry in each table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_valid | input | 1 | A retired instruction is presented |
| ret_pc | input | PC_W | PC of the retired instruction |
| ret_kind | input | 2 | 0 non-control, 1 conditional, 2 indirect, 3 other control |
| ret_taken | input | 1 | Direction of a conditional branch |
| ret_target | input | PC_W | Target of an indirect branch |
| dem_valid | input | 1 | Demotion request after a fired assertion |
| dem_indirect | input | 1 | Demotion selects the indirect table |
| dem_pc | input | PC_W | PC of the branch to demote |
| frm_valid | output | 1 | Frame descriptor strobe |
| frm_start_pc | output | PC_W | First PC of the reported frame |
| frm_len | output | $clog2(MAX_LEN+1) | Instructions in the reported frame |
| frm_asserts | output | $clog2(MAX_LEN+1) | Promoted branches in the reported frame |

## Verification
The bound checker enforces on every cycle the properties of each descriptor taken alone:
- the strobe lasts a single cycle;
- a reported length lies above MIN_LEN and at or below MAX_LEN;
- the assertion count never exceeds the length;
- every report follows a retired instruction;
- the payload holds between reports.

Whether a given branch is promoted at exactly the right repetition, whether saturation, aliasing and demotion move the counts correctly, and whether frames start at the right PC all depend on history. Only the bench's scenarios can show these, using its arithmetic model of the tables and the frame controller.

// File: rtl/fb_pkg.sv
package fb_pkg;

    typedef enum logic [1:0] {
        K_PLAIN = 2'd0,
        K_COND  = 2'd1,
        K_IND   = 2'd2,
        K_OTHER = 2'd3
    } ikind_e;

    typedef enum logic [1:0] {
        S_SEEK  = 2'd0,
        S_ARMED = 2'd1,
        S_BUILD = 2'd2
    } fstate_e;

endpackage

// File: rtl/fb_bias_table.sv
module fb_bias_table #(
    parameter int PC_W       = 16,
    parameter int IDX_W      = 3,
    parameter int CNT_W      = 3,
    parameter int VAL_W      = 1,
    parameter int PROMOTE_TH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [PC_W-1:0]  lk_pc,
    input  logic [VAL_W-1:0] lk_val,
    output logic             lk_promoted,
    input  logic             dm_valid,
    input  logic [PC_W-1:0]  dm_pc
);
    localparam int              ENTRIES = 1 << IDX_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] TH      = CNT_W'(PROMOTE_TH);

    function automatic logic [IDX_W-1:0] fold_pc(input logic [PC_W-1:0] pc);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int b = 0; b < PC_W; b++) begin
            r[b % IDX_W] = r[b % IDX_W] ^ pc[b];
        end
        return r;
    endfunction

    logic [VAL_W-1:0] val_q [ENTRIES];
    logic [CNT_W-1:0] cnt_q [ENTRIES];

    logic [IDX_W-1:0] lk_idx;
    logic [IDX_W-1:0] dm_idx;
    logic             same_outcome;

    assign lk_idx       = fold_pc(lk_pc);
    assign dm_idx       = fold_pc(dm_pc);
    assign same_outcome = (val_q[lk_idx] == lk_val);
    assign lk_promoted  = lk_valid && same_outcome && (cnt_q[lk_idx] >= TH);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                val_q[e] <= '0;
                cnt_q[e] <= '0;
            end
        end else begin
            if (lk_valid) begin
                if (same_outcome) begin
                    if (cnt_q[lk_idx] != CNT_MAX) begin
                        cnt_q[lk_idx] <= cnt_q[lk_idx] + 1'b1;
                    end
                end else begin
                    cnt_q[lk_idx] <= '0;
                    val_q[lk_idx] <= lk_val;
                end
            end
            // demotion written last: it wins over a same-entry update
            if (dm_valid) begin
                cnt_q[dm_idx] <= '0;
            end
        end
    end

endmodule

// File: rtl/fb_frame_fsm.sv
module fb_frame_fsm
    import fb_pkg::*;
#(
    parameter int PC_W    = 16,
    parameter int MIN_LEN = 4,
    parameter int MAX_LEN = 20,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ret_valid,
    input  ikind_e          ret_kind,
    input  logic [PC_W-1:0] ret_pc,
    input  logic            promoted,
    output logic            frm_valid,
    output logic [PC_W-1:0] frm_start_pc,
    output logic [LEN_W-1:0] frm_len,
    output logic [LEN_W-1:0] frm_asserts
);
    localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_LEN);
    localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(MIN_LEN);

    fstate_e          st_q, st_d;
    logic [LEN_W-1:0] len_q, len_d;
    logic [LEN_W-1:0] asr_q, asr_d;
    logic [PC_W-1:0]  start_q, start_d;

    logic             is_ctrl, ends_frame, is_assert;
    logic             close;
    logic [LEN_W-1:0] cl_len, cl_asr;
    logic [PC_W-1:0]  cl_start;

    assign is_ctrl    = (ret_kind != K_PLAIN);
    assign ends_frame = is_ctrl && !promoted;
    assign is_assert  = is_ctrl && promoted;

    // next-state and frame accumulation
    always_comb begin
        st_d     = st_q;
        len_d    = len_q;
        asr_d    = asr_q;
        start_d  = start_q;
        close    = 1'b0;
        cl_len   = '0;
        cl_asr   = '0;
        cl_start = start_q;
        unique case (st_q)
            S_SEEK: begin
                if (ret_valid && ends_frame) begin
                    st_d = S_ARMED;
                end
            end
            S_ARMED: begin
                if (ret_valid) begin
                    cl_start = ret_pc;
                    cl_len   = LEN_W'(1);
                    cl_asr   = {{(LEN_W-1){1'b0}}, is_assert};
                    if (ends_frame || (cl_len == LEN_CAP)) begin
                        close = 1'b1;
                        st_d  = S_ARMED;
                    end else begin
                        st_d    = S_BUILD;
                        start_d = ret_pc;
                        len_d   = cl_len;
                        asr_d   = cl_asr;
                    end
                end
            end
            S_BUILD: begin
                if (ret_valid) begin
                    cl_start = start_q;
                    cl_len   = len_q + 1'b1;
                    cl_asr   = asr_q + {{(LEN_W-1){1'b0}}, is_assert};
                    if (ends_frame || (cl_len == LEN_CAP)) begin
                        close = 1'b1;
                        st_d  = S_ARMED;
                    end else begin
                        len_d = cl_len;
                        asr_d = cl_asr;
                    end
                end
            end
            default: st_d = S_SEEK;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= S_SEEK;
            len_q   <= '0;
            asr_q   <= '0;
            start_q <= '0;
        end else begin
            st_q    <= st_d;
            len_q   <= len_d;
            asr_q   <= asr_d;
            start_q <= start_d;
        end
    end

    // descriptor outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frm_valid    <= 1'b0;
            frm_start_pc <= '0;
            frm_len      <= '0;
            frm_asserts  <= '0;
        end else begin
            frm_valid <= close && (cl_len > LEN_MIN);
            if (close && (cl_len > LEN_MIN)) begin
                frm_start_pc <= cl_start;
                frm_len      <= cl_len;
                frm_asserts  <= cl_asr;
            end
        end
    end

endmodule

// File: rtl/frame_builder.sv
module frame_builder
    import fb_pkg::*;
#(
    parameter int PC_W       = 16,
    parameter int IDX_W      = 3,
    parameter int CNT_W      = 3,
    parameter int PROMOTE_TH = 3,
    parameter int MIN_LEN    = 4,
    parameter int MAX_LEN    = 20,
    localparam int LEN_W     = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ret_valid,
    input  logic [PC_W-1:0]  ret_pc,
    input  logic [1:0]       ret_kind,
    input  logic             ret_taken,
    input  logic [PC_W-1:0]  ret_target,
    input  logic             dem_valid,
    input  logic             dem_indirect,
    input  logic [PC_W-1:0]  dem_pc,
    output logic             frm_valid,
    output logic [PC_W-1:0]  frm_start_pc,
    output logic [LEN_W-1:0] frm_len,
    output logic [LEN_W-1:0] frm_asserts
);
    ikind_e kind;
    logic   cond_lk, ind_lk;
    logic   cond_prom, ind_prom, promoted;

    assign kind     = ikind_e'(ret_kind);
    assign cond_lk  = ret_valid && (kind == K_COND);
    assign ind_lk   = ret_valid && (kind == K_IND);
    assign promoted = cond_prom || ind_prom;

    fb_bias_table #(
        .PC_W(PC_W), .IDX_W(IDX_W), .CNT_W(CNT_W),
        .VAL_W(1), .PROMOTE_TH(PROMOTE_TH)
    ) cond_tbl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .lk_valid    (cond_lk),
        .lk_pc       (ret_pc),
        .lk_val      (ret_taken),
        .lk_promoted (cond_prom),
        .dm_valid    (dem_valid && !dem_indirect),
        .dm_pc       (dem_pc)
    );

    fb_bias_table #(
        .PC_W(PC_W), .IDX_W(IDX_W), .CNT_W(CNT_W),
        .VAL_W(PC_W), .PROMOTE_TH(PROMOTE_TH)
    ) ind_tbl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .lk_valid    (ind_lk),
        .lk_pc       (ret_pc),
        .lk_val      (ret_target),
        .lk_promoted (ind_prom),
        .dm_valid    (dem_valid && dem_indirect),
        .dm_pc       (dem_pc)
    );

    fb_frame_fsm #(
        .PC_W(PC_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)
    ) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ret_valid    (ret_valid),
        .ret_kind     (kind),
        .ret_pc       (ret_pc),
        .promoted     (promoted),
        .frm_valid    (frm_valid),
        .frm_start_pc (frm_start_pc),
        .frm_len      (frm_len),
        .frm_asserts  (frm_asserts)
    );

endmodule

// File: rtl/fb_checker.sv
module fb_checker #(
    parameter int PC_W    = 16,
    parameter int MIN_LEN = 4,
    parameter int MAX_LEN = 20,
    parameter int LEN_W   = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ret_valid,
    input logic             frm_valid,
    input logic [PC_W-1:0]  frm_start_pc,
    input logic [LEN_W-1:0] frm_len,
    input logic [LEN_W-1:0] frm_asserts
);
    p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> !frm_valid);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_valid |-> ($stable(frm_len) && $stable(frm_asserts) && $stable(frm_start_pc)));

    p_min_size_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |-> (int'(frm_len) > MIN_LEN));

    p_len_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |-> (int'(frm_len) <= MAX_LEN));

    p_asserts_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |-> (frm_asserts <= frm_len));

    p_after_retire_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |-> $past(ret_valid));

endmodule

bind frame_builder fb_checker #(
    .PC_W(PC_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ret_valid    (ret_valid),
    .frm_valid    (frm_valid),
    .frm_start_pc (frm_start_pc),
    .frm_len      (frm_len),
    .frm_asserts  (frm_asserts)
);

// File: tb/frame_builder_tb_top.sv
`timescale 1ns/1ps
module frame_builder_tb_top;
    localparam int PC_W = 16;
    localparam int IDX_W = 3;
    localparam int CNT_W = 3;
    localparam int TH = 3;
    localparam int MINL = 4;
    localparam int MAXL = 20;
    localparam int LEN_W = $clog2(MAXL + 1);
    localparam int ENT = 1 << IDX_W;
    localparam int CMAX = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ret_valid = 1'b0;
    logic [PC_W-1:0] ret_pc = '0;
    logic [1:0] ret_kind = '0;
    logic ret_taken = 1'b0;
    logic [PC_W-1:0] ret_target = '0;
    logic dem_valid = 1'b0;
    logic dem_indirect = 1'b0;
    logic [PC_W-1:0] dem_pc = '0;
    logic frm_valid;
    logic [PC_W-1:0] frm_start_pc;
    logic [LEN_W-1:0] frm_len;
    logic [LEN_W-1:0] frm_asserts;

    always #2 clk = ~clk;

    frame_builder #(
        .PC_W(PC_W), .IDX_W(IDX_W), .CNT_W(CNT_W),
        .PROMOTE_TH(TH), .MIN_LEN(MINL), .MAX_LEN(MAXL)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_pc(ret_pc),
        .ret_kind(ret_kind), .ret_taken(ret_taken), .ret_target(ret_target),
        .dem_valid(dem_valid), .dem_indirect(dem_indirect), .dem_pc(dem_pc),
        .frm_valid(frm_valid), .frm_start_pc(frm_start_pc),
        .frm_len(frm_len), .frm_asserts(frm_asserts)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state, built from the requirements
    int cv [ENT];
    int cc [ENT];
    int iv [ENT];
    int ic [ENT];
    int mst = 0;
    int mlen = 0;
    int masr = 0;
    int mstart = 0;
    int e_v = 0, e_start = 0, e_len = 0, e_asr = 0;

    function automatic int fold(input int p);
        int r = 0;
        for (int b = 0; b < PC_W; b++) begin
            if (((p >> b) & 1) != 0) r = r ^ (1 << (b % IDX_W));
        end
        return r;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        chk(tag, "frm_valid", int'(frm_valid), e_v);
        chk(tag, "frm_start_pc", int'(frm_start_pc), e_start);
        chk(tag, "frm_len", int'(frm_len), e_len);
        chk(tag, "frm_asserts", int'(frm_asserts), e_asr);
    endtask

    task automatic step(input bit rv, input int k, input int pc, input bit tk,
                        input int tg, input bit dv, input bit dind, input int dpc,
                        input string tag);
        int ix;
        bit prom, ends_f, asr, cls;
        int nl, na, ns;
        @(negedge clk);
        ret_valid = rv; ret_kind = 2'(k); ret_pc = PC_W'(pc);
        ret_taken = tk; ret_target = PC_W'(tg);
        dem_valid = dv; dem_indirect = dind; dem_pc = PC_W'(dpc);
        e_v = 0;
        prom = 0;
        ix = fold(pc);
        if (rv && k == 1) begin
            prom = (cv[ix] == int'(tk)) && (cc[ix] >= TH);
            if (cv[ix] == int'(tk)) begin
                if (cc[ix] < CMAX) cc[ix]++;
            end else begin
                cc[ix] = 0; cv[ix] = int'(tk);
            end
        end
        if (rv && k == 2) begin
            prom = (iv[ix] == tg) && (ic[ix] >= TH);
            if (iv[ix] == tg) begin
                if (ic[ix] < CMAX) ic[ix]++;
            end else begin
                ic[ix] = 0; iv[ix] = tg;
            end
        end
        if (dv) begin
            if (dind) ic[fold(dpc)] = 0;
            else cc[fold(dpc)] = 0;
        end
        if (rv) begin
            ends_f = (k != 0) && !prom;
            asr = (k != 0) && prom;
            if (mst == 0) begin
                if (ends_f) mst = 1;
            end else begin
                if (mst == 1) begin ns = pc; nl = 1; na = int'(asr); end
                else begin ns = mstart; nl = mlen + 1; na = masr + int'(asr); end
                cls = ends_f || (nl == MAXL);
                if (cls) begin
                    mst = 1;
                    if (nl > MINL) begin
                        e_v = 1; e_start = ns; e_len = nl; e_asr = na;
                    end
                end else begin
                    mst = 2; mstart = ns; mlen = nl; masr = na;
                end
            end
        end
        @(posedge clk);
        #1;
        compare_all(tag);
    endtask

    task automatic plain(input int pc, input string tag);
        step(1, 0, pc, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic other(input int pc, input string tag);
        step(1, 3, pc, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic cond(input int pc, input bit tk, input string tag);
        step(1, 1, pc, tk, 0, 0, 0, 0, tag);
    endtask
    task automatic indir(input int pc, input int tg, input string tag);
        step(1, 2, pc, 0, tg, 0, 0, 0, tag);
    endtask
    task automatic idle(input string tag);
        step(0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic demote(input bit ind, input int pc, input string tag);
        step(0, 0, 0, 0, 0, 1, ind, pc, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int lfsr;
        for (int e = 0; e < ENT; e++) begin cv[e] = 0; cc[e] = 0; iv[e] = 0; ic[e] = 0; end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        compare_all("R1");

        // R6: nothing counted before the first unpromoted control instruction
        for (int i = 0; i < 8; i++) plain(16'h0010 + i, "R6");
        other(16'h0020, "R6");

        // R7 minimum size sweep: n plain then a closing control instruction
        for (int n = 0; n <= 8; n++) begin
            for (int i = 0; i < n; i++) plain(16'h0100 + 16 * n + i, "R7");
            other(16'h0180 + n, "R7");
            chk("R7", "reported iff len>MIN", int'(frm_valid), (n + 1 > MINL) ? 1 : 0);
            if (n + 1 > MINL) chk("R7", "len", int'(frm_len), n + 1);
        end

        // R9 pulse and hold
        idle("R9");
        chk("R9", "strobe dropped", int'(frm_valid), 0);
        chk("R9", "len held", int'(frm_len), 9);

        // R4 promotion loop: 3 plain + cond taken at 0x40, until forced close
        for (int it = 1; it <= 9; it++) begin
            for (int i = 0; i < 3; i++) plain(16'h0200 + 16 * it + i, "R4");
            cond(16'h0040, 1'b1, "R4");
        end
        chk("R8", "forced close len", int'(frm_len), 20);
        chk("R4", "assertions in frame", int'(frm_asserts), 5);
        chk("R4", "start pc", int'(frm_start_pc), 16'h0200 + 16 * 5);

        // R5 demotion: branch must requalify, so it ends the next frame
        demote(1'b0, 16'h0040, "R5");
        for (int i = 0; i < 5; i++) plain(16'h0300 + i, "R5");
        cond(16'h0040, 1'b1, "R5");
        chk("R5", "demoted branch ends frame", int'(frm_valid), 1);
        chk("R5", "no assertion", int'(frm_asserts), 0);
        chk("R5", "len", int'(frm_len), 6);

        // R8: 25 plain instructions -> forced close at 20
        for (int i = 0; i < 25; i++) plain(16'h0400 + i, "R8");
        other(16'h0500, "R8");
        chk("R8", "tail frame len", int'(frm_len), 6);
        chk("R8", "tail frame start", int'(frm_start_pc), 16'h0400 + 20);

        // R2 saturation and direction flips; R10 aliasing 0x40 vs 0x01
        for (int i = 0; i < 12; i++) cond(16'h0040, 1'b0, "R2");
        for (int i = 0; i < 3; i++) cond(16'h0001, 1'b0, "R10");
        cond(16'h0001, 1'b1, "R10");
        for (int i = 0; i < 6; i++) cond(16'h0040, 1'b1, "R2");

        // R3 indirect targets, separate from conditional table
        for (int i = 0; i < 7; i++) indir(16'h0051, 16'h0abc, "R3");
        indir(16'h0051, 16'h0def, "R3");
        for (int i = 0; i < 6; i++) indir(16'h0051, 16'h0def, "R3");
        demote(1'b1, 16'h0051, "R5");
        indir(16'h0051, 16'h0def, "R5");

        // R5 same-cycle demotion and update
        for (int i = 0; i < 5; i++) cond(16'h0002, 1'b1, "R5");
        step(1, 1, 16'h0002, 1'b1, 0, 1'b1, 1'b0, 16'h0002, "R5");
        cond(16'h0002, 1'b1, "R5");

        // mixed stream against the model
        lfsr = 16'hace1;
        for (int s = 0; s < 3000; s++) begin
            int r, k, pc;
            bit dv;
            lfsr = ((lfsr << 1) | (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1)) & 16'hffff;
            r = lfsr;
            k = (r & 7) < 4 ? 0 : ((r & 7) < 6 ? 1 : ((r & 7) == 6 ? 2 : 3));
            if ((r & 7) == 7 && ((r >> 3) & 1) == 1) k = 1;
            pc = 16'h0600 + ((r >> 4) & 3) * 16'h0011;
            dv = ((r >> 8) & 31) == 0;
            step(1, k, pc, ((r >> 10) & 7) != 0, ((r >> 13) & 7) == 0 ? 16'h0777 : 16'h0888,
                 dv, (r >> 6) & 1, pc, "R4");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule